// File: doc/BRIEF.md
# Strobed Row-Buffer DRAM Model

This block is a synthesizable behavioural model of a small dynamic memory. Its storage is a grid of 4 rows by 4 columns of 8-bit supercells, 16 supercells in total. Row and column addresses share one 2-bit address port and arrive one after the other. A falling row strobe opens a row by copying it whole into an internal row buffer. Each later falling column strobe then reads or writes one supercell of that buffer. A write also goes through to the backing array, so the data survives when the row is closed and opened again.

Each row carries an age counter. Opening a row restarts the count for that row, and so does a refresh request made while no row is open. If a row goes longer than a parameterized number of clock cycles without either, a sticky violation flag is raised. A column strobe that finds no ready row gives a one-cycle protocol error and leaves the data pins unchanged. Storage is written as a row-wide memory with a registered read port so that block RAM can be inferred.

Top module: `dram_grid`

## Requirements
- R1: After synchronous reset, `dout` is 0 and `dout_valid`, `proto_err` and `refresh_err` are all 0.
- R2: A row strobe falling edge latches `addr` as the row, where a falling edge means `row_n` is sampled 0 after being sampled 1. The row becomes ready two clock edges later. A column falling edge sampled at the first edge after the row edge is a protocol error.
- R3: A column falling edge with `wr_en`=0 on a ready row puts the supercell at (open row, `addr` as column) on `dout` at that edge. `dout_valid` goes to 1 at the same edge, stays 1 while `col_n` is held low, and returns to 0 at the first edge where `col_n` is sampled high.
- R4: A column falling edge with `wr_en`=1 on a ready row stores `din` into the row buffer and the array at that column, and leaves `dout_valid` at 0. A later read of that column in the same open row returns `din`.
- R5: Several column accesses may be made in one open row, with no new row strobe between them. Data written through the buffer is still there after the row is closed and opened again.
- R6: A column falling edge when no row is ready raises `proto_err` for exactly one cycle, starting at that edge. `dout_valid` stays 0 and `dout` keeps its value.
- R7: A clock edge with `row_n` sampled 1 closes the row. A column strobe after that is a protocol error until a new row strobe edge comes.
- R8: A `refresh_req` sampled with no row open and no row strobe edge rewrites the row addressed by `addr` with its own contents and restarts that row's age count. Data read afterwards is unchanged.
- R9: `refresh_err` rises once a row has gone `REFRESH_LIMIT` cycles with neither a row strobe edge nor an accepted refresh. It then stays 1 until reset.
- R10: A `refresh_req` made while a row is open is ignored and does not restart any row's age count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_n | input | 1 | Active-low row strobe |
| col_n | input | 1 | Active-low column strobe |
| wr_en | input | 1 | Write select, sampled at the column strobe edge |
| refresh_req | input | 1 | Refresh request for the row on `addr` |
| addr | input | 2 | Shared row/column address |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| dout_valid | output | 1 | Read data on `dout` is valid |
| proto_err | output | 1 | One-cycle pulse for a column strobe with no ready row |
| refresh_err | output | 1 | Sticky refresh-deadline violation |

## Verification
The assertions assume that the strobes are sampled cleanly on the clock. They assume that `row_n` returns high before a row is opened again, so a strobe edge can never meet an open row, and that `col_n` goes high between column accesses. The stimulus drives every pin on the falling clock edge. Every access it makes is a complete open, column and close sequence, and a refresh is offered only while `row_n` is high, except for the one deliberate refresh inside an open row. Reads come only after the targeted cells have been written, because the storage has no reset.

// File: rtl/dram_grid_pkg.sv
package dram_grid_pkg;
  localparam int ROWS_DEFAULT  = 4;
  localparam int COLS_DEFAULT  = 4;
  localparam int WIDTH_DEFAULT = 8;

  typedef enum logic [1:0] {
    COL_IDLE  = 2'd0,
    COL_READ  = 2'd1,
    COL_WRITE = 2'd2,
    COL_FAULT = 2'd3
  } col_op_e;
endpackage

// File: rtl/dram_grid_array.sv
module dram_grid_array #(
  parameter int ROWS = 4,
  parameter int LINE_W = 32,
  localparam int RA_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [RA_W-1:0]   rd_addr,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINE_W-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_line;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_line <= cells[rd_addr];
  end
endmodule

// File: rtl/dram_grid_rowbuf.sv
module dram_grid_rowbuf
  import dram_grid_pkg::*;
#(
  parameter int COLS = 4,
  parameter int WIDTH = 8,
  localparam int CA_W = $clog2(COLS),
  localparam int LINE_W = COLS * WIDTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_start,
  input  logic              close,
  input  logic              col_n,
  input  logic [LINE_W-1:0] rd_line,
  input  col_op_e           op,
  input  logic [CA_W-1:0]   col,
  input  logic [WIDTH-1:0]  din,
  output logic              ready,
  output logic              wr_go,
  output logic [LINE_W-1:0] wr_line,
  output logic [WIDTH-1:0]  dout,
  output logic              dout_valid,
  output logic              proto_err
);
  logic              load_pend;
  logic [LINE_W-1:0] line;

  always_comb begin
    wr_line = line;
    wr_line[col*WIDTH +: WIDTH] = din;
    wr_go = (op == COL_WRITE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_pend  <= 1'b0;
      ready      <= 1'b0;
      line       <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
      proto_err  <= 1'b0;
    end else begin
      load_pend <= load_start;
      if (close) begin
        ready <= 1'b0;
      end else if (load_pend) begin
        ready <= 1'b1;
        line  <= rd_line;
      end else if (op == COL_WRITE) begin
        line <= wr_line;
      end
      if (op == COL_READ) begin
        dout       <= line[col*WIDTH +: WIDTH];
        dout_valid <= 1'b1;
      end else if (col_n || close) begin
        dout_valid <= 1'b0;
      end
      proto_err <= (op == COL_FAULT);
    end
  end

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> !proto_err); // R6
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> (!dout_valid && $stable(dout))); // R6
endmodule

// File: rtl/dram_grid_refresh.sv
module dram_grid_refresh #(
  parameter int ROWS = 4,
  parameter int LIMIT = 1000,
  localparam int RA_W = $clog2(ROWS),
  localparam int AGE_W = $clog2(LIMIT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            touch,
  input  logic [RA_W-1:0] touch_row,
  output logic            refresh_err
);
  logic [ROWS-1:0] expired;

  for (genvar r = 0; r < ROWS; r++) begin : g_age
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk) begin
      if (rst) begin
        age <= '0;
      end else if (touch && (touch_row == RA_W'(r))) begin
        age <= '0;
      end else if (age != AGE_W'(LIMIT)) begin
        age <= age + 1'b1;
      end
    end
    assign expired[r] = (age == AGE_W'(LIMIT));
  end

  always_ff @(posedge clk) begin
    if (rst) refresh_err <= 1'b0;
    else if (|expired) refresh_err <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    refresh_err |=> refresh_err); // R9
endmodule

// File: rtl/dram_grid.sv
module dram_grid
  import dram_grid_pkg::*;
#(
  parameter int ROWS = ROWS_DEFAULT,
  parameter int COLS = COLS_DEFAULT,
  parameter int WIDTH = WIDTH_DEFAULT,
  parameter int REFRESH_LIMIT = 1000,
  localparam int RA_W = $clog2(ROWS),
  localparam int CA_W = $clog2(COLS),
  localparam int ADDR_W = (RA_W > CA_W) ? RA_W : CA_W,
  localparam int LINE_W = COLS * WIDTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_n,
  input  logic              col_n,
  input  logic              wr_en,
  input  logic              refresh_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  din,
  output logic [WIDTH-1:0]  dout,
  output logic              dout_valid,
  output logic              proto_err,
  output logic              refresh_err
);
  logic            row_n_q, col_n_q;
  logic            row_open;
  logic [RA_W-1:0] row_addr;
  logic            row_fall, col_fall, ref_go;
  logic            ref_pend;
  logic [RA_W-1:0] ref_row_q;
  logic            row_ready, buf_wr;
  logic [LINE_W-1:0] rd_line, buf_line, arr_wline;
  logic [RA_W-1:0] arr_waddr;
  logic            arr_we;
  col_op_e         op;

  assign row_fall = !row_n && row_n_q;
  assign col_fall = !col_n && col_n_q;
  assign ref_go   = refresh_req && !row_open && !row_fall;

  always_comb begin
    op = COL_IDLE;
    if (col_fall) begin
      if (!row_ready) op = COL_FAULT;
      else if (wr_en) op = COL_WRITE;
      else            op = COL_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_n_q   <= 1'b1;
      col_n_q   <= 1'b1;
      row_open  <= 1'b0;
      row_addr  <= '0;
      ref_pend  <= 1'b0;
      ref_row_q <= '0;
    end else begin
      row_n_q  <= row_n;
      col_n_q  <= col_n;
      ref_pend <= ref_go;
      if (ref_go) ref_row_q <= addr[RA_W-1:0];
      if (row_n) begin
        row_open <= 1'b0;
      end else if (row_fall) begin
        row_open <= 1'b1;
        row_addr <= addr[RA_W-1:0];
      end
    end
  end

  assign arr_we    = buf_wr || ref_pend;
  assign arr_waddr = buf_wr ? row_addr : ref_row_q;
  assign arr_wline = buf_wr ? buf_line : rd_line;

  dram_grid_array #(.ROWS(ROWS), .LINE_W(LINE_W)) u_array (
    .clk     (clk),
    .rd_en   (row_fall || ref_go),
    .rd_addr (addr[RA_W-1:0]),
    .rd_line (rd_line),
    .wr_en   (arr_we),
    .wr_addr (arr_waddr),
    .wr_line (arr_wline)
  );

  dram_grid_rowbuf #(.COLS(COLS), .WIDTH(WIDTH)) u_rowbuf (
    .clk        (clk),
    .rst        (rst),
    .load_start (row_fall),
    .close      (row_n),
    .col_n      (col_n),
    .rd_line    (rd_line),
    .op         (op),
    .col        (addr[CA_W-1:0]),
    .din        (din),
    .ready      (row_ready),
    .wr_go      (buf_wr),
    .wr_line    (buf_line),
    .dout       (dout),
    .dout_valid (dout_valid),
    .proto_err  (proto_err)
  );

  dram_grid_refresh #(.ROWS(ROWS), .LIMIT(REFRESH_LIMIT)) u_refresh (
    .clk         (clk),
    .rst         (rst),
    .touch       (row_fall || ref_go),
    .touch_row   (addr[RA_W-1:0]),
    .refresh_err (refresh_err)
  );

  AST_READY_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
    $rose(row_ready) |-> $past(row_open)); // R2
  AST_CLOSE_DROPS_ROW: assert property (@(posedge clk) disable iff (rst)
    row_n |=> !row_ready); // R7
  AST_VALID_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_valid) |-> $past(row_ready)); // R3
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
    !(buf_wr && ref_pend)); // R8
endmodule

// File: tb/dram_grid_test.sv
module dram_grid_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       row_n = 1'b1, col_n = 1'b1, wr_en = 1'b0, refresh_req = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_valid, proto_err, refresh_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] model [4][4];

  localparam int LIM = 400;

  // {row, col, data}
  localparam logic [11:0] VEC [16] = '{
    {2'd2, 2'd1, 8'h5A}, {2'd0, 2'd3, 8'hC3}, {2'd3, 2'd0, 8'h17}, {2'd1, 2'd2, 8'hE8},
    {2'd0, 2'd0, 8'h01}, {2'd3, 2'd3, 8'hFF}, {2'd1, 2'd0, 8'h80}, {2'd2, 2'd2, 8'h6D},
    {2'd0, 2'd1, 8'h92}, {2'd1, 2'd3, 8'h3B}, {2'd2, 2'd0, 8'hA4}, {2'd3, 2'd1, 8'h49},
    {2'd1, 2'd1, 8'h00}, {2'd0, 2'd2, 8'h7E}, {2'd3, 2'd2, 8'hD1}, {2'd2, 2'd3, 8'h25}
  };

  always #2 clk = ~clk;

  dram_grid #(.REFRESH_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .row_n(row_n), .col_n(col_n), .wr_en(wr_en),
    .refresh_req(refresh_req), .addr(addr), .din(din), .dout(dout),
    .dout_valid(dout_valid), .proto_err(proto_err), .refresh_err(refresh_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic open_row(input logic [1:0] r);
    @(negedge clk); row_n = 1'b0; addr = r;
    ticks(2);
  endtask

  task automatic close_row();
    row_n = 1'b1; @(negedge clk);
  endtask

  task automatic col_op(input logic we, input logic [1:0] r, input logic [1:0] c,
                        input logic [7:0] d, input string tag);
    col_n = 1'b0; addr = c; wr_en = we; din = d;
    @(negedge clk);
    if (we) begin
      chk(tag, dout_valid, 0);
      model[r][c] = d;
    end else begin
      chk(tag, dout, model[r][c]);
      chk(tag, dout_valid, 1);
    end
    col_n = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    if (!we) chk("R3", dout_valid, 0);
  endtask

  task automatic access(input logic we, input logic [1:0] r, input logic [1:0] c,
                        input logic [7:0] d, input string tag);
    open_row(r);
    col_op(we, r, c, d, tag);
    close_row();
  endtask

  task automatic refresh_row(input logic [1:0] r);
    refresh_req = 1'b1; addr = r; @(negedge clk);
    refresh_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    ticks(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", dout, 0); chk("R1", dout_valid, 0);
    chk("R1", proto_err, 0); chk("R1", refresh_err, 0);

    // R6: column strobe with no row
    col_n = 1'b0; addr = 2'd1; @(negedge clk);
    chk("R6", proto_err, 1); chk("R6", dout_valid, 0);
    @(negedge clk); chk("R6", proto_err, 0);
    col_n = 1'b1; @(negedge clk);

    // table walk: write every cell, then read every cell back (R4)
    for (int i = 0; i < 16; i++)
      access(1'b1, VEC[i][11:10], VEC[i][9:8], VEC[i][7:0], "R4");
    for (int i = 15; i >= 0; i--)
      access(1'b0, VEC[i][11:10], VEC[i][9:8], 8'h00, "R3");

    // R2: column one edge after row strobe is too early
    @(negedge clk); row_n = 1'b0; addr = 2'd2;
    @(negedge clk); col_n = 1'b0; addr = 2'd1;
    @(negedge clk); chk("R2", proto_err, 1); chk("R2", dout_valid, 0);
    col_n = 1'b1; @(negedge clk);
    col_op(1'b0, 2'd2, 2'd1, 8'h00, "R2");
    // R3: valid held while column strobe stays low
    col_n = 1'b0; addr = 2'd3; @(negedge clk);
    chk("R3", dout, model[2][3]); chk("R3", dout_valid, 1);
    @(negedge clk); chk("R3", dout_valid, 1);
    col_n = 1'b1; @(negedge clk); chk("R3", dout_valid, 0);
    // R5 / R4: page-mode write then reads in the same open row
    col_op(1'b1, 2'd2, 2'd0, 8'hB6, "R4");
    col_op(1'b0, 2'd2, 2'd0, 8'h00, "R4");
    col_op(1'b0, 2'd2, 2'd2, 8'h00, "R5");
    close_row();
    access(1'b0, 2'd2, 2'd0, 8'h00, "R5");

    // R7: column after close is an error, dout kept (R6)
    held = dout;
    col_n = 1'b0; addr = 2'd0; @(negedge clk);
    chk("R7", proto_err, 1); chk("R6", dout, held);
    col_n = 1'b1; @(negedge clk);

    // R8 / R9 / R10: refresh deadline
    for (int r = 0; r < 4; r++) refresh_row(2'(r));
    chk("R9", refresh_err, 0);
    ticks(370);
    chk("R8", refresh_err, 0);
    for (int r = 0; r < 3; r++) refresh_row(2'(r));
    open_row(2'd0);
    refresh_row(2'd3);
    close_row();
    access(1'b0, 2'd1, 2'd2, 8'h00, "R8");
    chk("R10", refresh_err, 0);
    ticks(50);
    chk("R10", refresh_err, 1);
    for (int r = 0; r < 4; r++) refresh_row(2'(r));
    ticks(10);
    chk("R9", refresh_err, 1);
    access(1'b0, 2'd3, 2'd1, 8'h00, "R8");

    rst = 1'b1; ticks(2); rst = 1'b0; @(negedge clk);
    chk("R1", refresh_err, 0); chk("R1", dout, 0); chk("R1", dout_valid, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule